// File: doc/BRIEF.md
# Element-Width SIMD Integer ALU with Byte Write Mask

This block is a 32-bit integer ALU that splits its datapath into independent lanes chosen at run time by an element-width input. It handles four 8-bit lanes, two 16-bit lanes or one 32-bit lane. Each source byte arrives already sitting in the byte position that the result will occupy in the destination register. The result therefore leaves the ALU in place, and no realignment happens after the computation.

A per-element predicate sets a byte write-enable mask that leaves the block together with the result. The register file can then write only the bytes of active elements. A lane never extends its result into neighbouring bytes; any widening is left to a separate move. Every operation takes one clock. Inputs sampled at a rising edge show up on the registered outputs right after that edge.

Top module: `simd_lane_alu`

## Requirements
- R1: After reset is asserted (rst_n low), `result` and `byte_we` are both zero.
- R2: Inputs present at a rising clock edge set `result` and `byte_we` immediately after that edge. The outputs hold their values between edges.
- R3: `elw` selects the lane width: 0 gives four 8-bit lanes, 1 gives two 16-bit lanes, and 2 or 3 give one 32-bit lane. Lane i occupies bits [i*w +: w].
- R4: Opcode 0 (add) adds each lane modulo 2^w. No carry crosses a lane boundary.
- R5: Opcode 1 (sub) computes a minus b in each lane modulo 2^w. No borrow crosses a lane boundary.
- R6: Opcodes 2 (and), 3 (or) and 4 (xor) are bitwise over all 32 bits at every lane width.
- R7: Opcodes 5 (shift left), 6 (logical shift right) and 7 (arithmetic shift right, using the lane's own top bit) shift each lane of `op_a`. The shift amount is that lane's `op_b` value modulo the lane width. Bits never move between lanes.
- R8: Bit k of `byte_we` equals the predicate bit of the element that holds byte k. For 8-bit lanes that is pred[k], for 16-bit lanes pred[k/2], and for 32-bit lanes pred[0].
- R9: Predicate bits above the number of elements for the current width have no effect on `byte_we` or `result`.
- R10: `result` holds the computed value in every byte, whether or not that byte's predicate is set. The mask alone carries the predication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First source, byte-aligned to destination |
| op_b | input | 32 | Second source or per-lane shift amount |
| opcode | input | 3 | 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shl, 6 shr, 7 sar |
| elw | input | 2 | Element width: 0 = 8, 1 = 16, 2/3 = 32 |
| pred | input | 4 | Per-element predicate, bit i for element i |
| result | output | 32 | Registered lane-wise result |
| byte_we | output | 4 | Registered byte write-enable mask |

## Verification
On every cycle, the assertions check the structure of the mask against the width sampled one cycle earlier: the bytes of a 16-bit lane agree, and a 32-bit mask is all-or-nothing. They also check that an all-zero predicate clears the mask, and that the bitwise opcodes and a self-xor produce the expected word. Carry and borrow isolation at lane boundaries, the arithmetic of shifts modulo the lane width, and the handling of elw code 3 can only be seen through the bench's directed corner cases and its seeded random comparison against a lane-by-lane reference model.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
    localparam int DATA_W = 32;
    localparam int NBYTES = DATA_W / 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6,
        OP_SAR = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_32X = 2'd3
    } elw_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [NBYTES-1:0] we;
    } alu_state_t;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
    import simd_alu_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic [NB*8-1:0] a,
    input  logic [NB*8-1:0] b,
    input  logic            sub,
    input  elw_e            elw,
    output logic [NB*8-1:0] sum
);
    logic [NB*8-1:0] b_eff;
    logic [8:0]      part;
    logic            carry;

    assign b_eff = sub ? ~b : b;

    // ripple across bytes; a lane boundary reloads the carry with sub
    always_comb begin
        carry = 1'b0;
        part  = '0;
        sum   = '0;
        for (int k = 0; k < NB; k++) begin
            if ((k % 4 == 0) || (elw == EW_8) || (elw == EW_16 && (k % 2 == 0)))
                carry = sub;
            part = {1'b0, a[k*8 +: 8]} + {1'b0, b_eff[k*8 +: 8]} + {8'd0, carry};
            sum[k*8 +: 8] = part[7:0];
            carry = part[8];
        end
    end
endmodule

// File: rtl/lane_shift.sv
module lane_shift
    import simd_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [1:0]    kind,   // 0 shl, 1 shr, 2 sar
    input  elw_e          elw,
    output logic [DW-1:0] res
);
    logic [2:0][DW-1:0] by_w;

    for (genvar g = 0; g < 3; g++) begin : g_width
        localparam int LW  = 8 << g;
        localparam int NL  = DW / LW;
        localparam int SHW = $clog2(LW);
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0]  x;
            logic [SHW-1:0] sh;
            logic [LW-1:0]  r;
            assign x  = a[l*LW +: LW];
            assign sh = b[l*LW +: SHW];
            always_comb begin
                case (kind)
                    2'd0:    r = x << sh;
                    2'd1:    r = x >> sh;
                    default: r = $unsigned($signed(x) >>> sh);
                endcase
            end
            assign by_w[g][l*LW +: LW] = r;
        end
    end

    always_comb begin
        case (elw)
            EW_8:    res = by_w[0];
            EW_16:   res = by_w[1];
            default: res = by_w[2];
        endcase
    end
endmodule

// File: rtl/byte_mask_gen.sv
module byte_mask_gen
    import simd_alu_pkg::*;
#(
    parameter int NB = NBYTES
) (
    input  logic [NB-1:0] pred,
    input  elw_e          elw,
    output logic [NB-1:0] we
);
    always_comb begin
        for (int k = 0; k < NB; k++) begin
            case (elw)
                EW_8:    we[k] = pred[k];
                EW_16:   we[k] = pred[k/2];
                default: we[k] = pred[k/4];
            endcase
        end
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        opcode,
    input  logic [1:0]        elw,
    input  logic [NBYTES-1:0] pred,
    output logic [DATA_W-1:0] result,
    output logic [NBYTES-1:0] byte_we
);
    alu_state_t        state_d, state_q;
    alu_op_e           op;
    elw_e              ew;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] shift_res;
    logic [NBYTES-1:0] mask;
    logic [1:0]        shift_kind;

    assign op = alu_op_e'(opcode);
    assign ew = elw_e'(elw);

    always_comb begin
        case (op)
            OP_SHL:  shift_kind = 2'd0;
            OP_SHR:  shift_kind = 2'd1;
            default: shift_kind = 2'd2;
        endcase
    end

    lane_addsub #(.NB(NBYTES)) u_addsub (
        .a   (op_a),
        .b   (op_b),
        .sub (op == OP_SUB),
        .elw (ew),
        .sum (arith_res)
    );

    lane_shift #(.DW(DATA_W)) u_shift (
        .a    (op_a),
        .b    (op_b),
        .kind (shift_kind),
        .elw  (ew),
        .res  (shift_res)
    );

    byte_mask_gen #(.NB(NBYTES)) u_mask (
        .pred (pred),
        .elw  (ew),
        .we   (mask)
    );

    always_comb begin
        state_d    = state_q;
        state_d.we = mask;
        case (op)
            OP_ADD, OP_SUB:         state_d.res = arith_res;
            OP_AND:                 state_d.res = op_a & op_b;
            OP_OR:                  state_d.res = op_a | op_b;
            OP_XOR:                 state_d.res = op_a ^ op_b;
            default:                state_d.res = shift_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result  = state_q.res;
    assign byte_we = state_q.we;
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
    import simd_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [2:0]        opcode,
    input logic [1:0]        elw,
    input logic [NBYTES-1:0] pred,
    input logic [DATA_W-1:0] result,
    input logic [NBYTES-1:0] byte_we
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && byte_we == '0));                                  // R1

    AST_MASK_PAIRS_16: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(elw) == 2'd1) |-> (byte_we[0] == byte_we[1] && byte_we[2] == byte_we[3])); // R8

    AST_MASK_WHOLE_32: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(elw[1])) |-> (byte_we == '0 || byte_we == '1));           // R8

    AST_NO_PRED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(pred) == '0) |-> byte_we == '0);                          // R8

    AST_AND_BITWISE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode) == 3'd2) |-> result == ($past(op_a) & $past(op_b))); // R6

    AST_XOR_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode) == 3'd4 && $past(op_a) == $past(op_b)) |-> result == '0); // R6

    AST_ADD_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(opcode) == 3'd0 && $past(op_b) == '0) |-> result == $past(op_a)); // R4
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .opcode  (opcode),
    .elw     (elw),
    .pred    (pred),
    .result  (result),
    .byte_we (byte_we)
);

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_a, op_b;
    logic [2:0]  opcode;
    logic [1:0]  elw;
    logic [3:0]  pred;
    logic [31:0] result;
    logic [3:0]  byte_we;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_lane_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .opcode(opcode), .elw(elw), .pred(pred),
        .result(result), .byte_we(byte_we)
    );

    function automatic int lane_w(input logic [1:0] e);
        return (e == 2'd0) ? 8 : (e == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                            input logic [2:0] op, input logic [1:0] e);
        int w = lane_w(e);
        logic [31:0] lm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        logic [31:0] out = '0;
        for (int i = 0; i < 32 / w; i++) begin
            logic [31:0] x = (a >> (i * w)) & lm;
            logic [31:0] y = (b >> (i * w)) & lm;
            int sh = int'(y % w);
            logic [31:0] xs = x[w-1] ? (x | ~lm) : x;
            logic [31:0] r;
            case (op)
                3'd0: r = x + y;
                3'd1: r = x - y;
                3'd2: r = x & y;
                3'd3: r = x | y;
                3'd4: r = x ^ y;
                3'd5: r = x << sh;
                3'd6: r = x >> sh;
                default: r = $unsigned($signed(xs) >>> sh);
            endcase
            out = out | ((r & lm) << (i * w));
        end
        return out;
    endfunction

    function automatic logic [3:0] ref_we(input logic [3:0] p, input logic [1:0] e);
        int bpe = lane_w(e) / 8;
        logic [3:0] m;
        for (int k = 0; k < 4; k++) m[k] = p[k / bpe];
        return m;
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2, 3'd3, 3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive at negedge, sample just after the following posedge
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [2:0] op, input logic [1:0] e, input logic [3:0] p);
        @(negedge clk);
        op_a = a; op_b = b; opcode = op; elw = e; pred = p;
        @(posedge clk); #1;
        check32(tag, result, ref_res(a, b, op, e));
        check32("R8", {28'd0, byte_we}, {28'd0, ref_we(p, e)});
    endtask

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 1'b0; op_a = 32'hFFFF_FFFF; op_b = 32'h1; opcode = 3'd0; elw = 2'd0; pred = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check32("R1", result, 32'd0);
        check32("R1", {28'd0, byte_we}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // carry isolation at each width
        run_op("R4", 32'h00FF_00FF, 32'h0001_0001, 3'd0, 2'd0, 4'hF);
        check32("R4", result, 32'h0000_0000);
        run_op("R4", 32'h0000_FFFF, 32'h0000_0001, 3'd0, 2'd1, 4'h3);
        check32("R4", result, 32'h0000_0000);
        run_op("R4", 32'h0000_FFFF, 32'h0000_0001, 3'd0, 2'd2, 4'h1);
        check32("R4", result, 32'h0001_0000);
        // borrow isolation
        run_op("R5", 32'h0000_0000, 32'h0000_0001, 3'd1, 2'd0, 4'hF);
        check32("R5", result, 32'h0000_00FF);
        run_op("R5", 32'h0001_0000, 32'h0000_0001, 3'd1, 2'd1, 4'h3);
        check32("R5", result, 32'h0001_FFFF);
        // code 3 behaves as 32-bit lane
        run_op("R3", 32'h0000_FFFF, 32'h0000_0001, 3'd0, 2'd3, 4'h1);
        check32("R3", result, 32'h0001_0000);
        check32("R3", {28'd0, byte_we}, 32'hF);
        // shift amount modulo lane width, sign of lane top bit
        run_op("R7", 32'h8080_8080, 32'h0909_0909, 3'd7, 2'd0, 4'hF);
        check32("R7", result, 32'hC0C0_C0C0);
        run_op("R7", 32'h0000_8001, 32'h0000_0011, 3'd5, 2'd1, 4'h3);
        check32("R7", result, 32'h0000_0002);
        // upper predicate bits ignored
        run_op("R9", 32'h1234_5678, 32'h1111_1111, 3'd3, 2'd2, 4'hE);
        check32("R9", {28'd0, byte_we}, 32'h0);
        check32("R9", result, 32'h1335_5779);
        run_op("R9", 32'h0, 32'h0, 3'd0, 2'd1, 4'hC);
        check32("R9", {28'd0, byte_we}, 32'h0);
        // result present despite zero predicate
        run_op("R10", 32'h0102_0304, 32'h1010_1010, 3'd0, 2'd0, 4'h0);
        check32("R10", result, 32'h1112_1314);
        // outputs hold between edges, update at the edge
        @(negedge clk);
        op_a = 32'hAAAA_5555; op_b = 32'hFFFF_0000; opcode = 3'd4; elw = 2'd2; pred = 4'h1;
        #1 check32("R2", result, 32'h1112_1314);
        @(posedge clk); #1;
        check32("R2", result, 32'h5555_5555);

        for (int i = 0; i < 400; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            run_op(op_tag(op), $urandom, $urandom, op, 2'($urandom_range(0, 3)), 4'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule